// File: doc/BRIEF.md
# Misaligned Source Word Realigner

This block sits in the read path of a DMA engine. It returns one 32-bit source word for a byte address that may not be word aligned. The DMA sequencer hands it a byte address and a one-bit half-word select. The block then runs one or two aligned reads on a simple valid/ready read master toward memory and returns the result on a response port. The sequencer must consume that response before the block takes another request.

If bit 0 of the address is clear, the block issues a single aligned read and returns that data untouched. If bit 0 is set, it reads two consecutive aligned words. It splices the lower three bytes of the first word above the top byte of the second word. It then shifts the spliced word right by zero or sixteen bits, as the select input asks.

Every read address is the request address with the two low bits cleared and everything above bit 26 cleared. The second read adds 4 to that value and does not mask the sum again.

Top module: `src_word_realigner`

## Requirements
- R1: When req_addr_i[0] is 0, exactly one memory read is issued, at the masked address, and rsp_data_o equals that read's data unchanged.
- R2: When req_addr_i[0] is 1, exactly two memory reads are issued: the first at the masked address, the second at the masked address plus 4 (the sum is not masked again).
- R3: On the odd path with req_shift_i = 0, rsp_data_o = {first[23:0], second[31:24]}.
- R4: On the odd path with req_shift_i = 1, rsp_data_o is the spliced word of R3 shifted right by 16 with zero fill.
- R5: The masked address is req_addr_i AND 0x07FFFFFC, so every first read has bits 1:0 and 31:27 at zero.
- R6: rsp_valid_o rises in the cycle after the clock edge at which the last read's data is accepted. It then stays high with rsp_data_o stable until rsp_ready_i is sampled high.
- R7: req_ready_o is high only while the block is idle. A request offered while a transfer or an unconsumed response is in progress is not taken.
- R8: At most one read is outstanding. The second read is issued only after the first has returned. A read request keeps mem_req_valid_o high with a stable address until mem_req_ready_i accepts it.
- R9: While rst_ni is low, and right after it is released, req_ready_o = 1, rsp_valid_o = 0 and mem_req_valid_o = 0. A reset during a transfer abandons it.
- R10: On the aligned path req_shift_i has no effect: the data is returned unshifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Sequencer offers a request |
| req_ready_o | output | 1 | Block is idle and takes the request |
| req_addr_i | input | 32 | Source byte address, possibly misaligned |
| req_shift_i | input | 1 | Half-word right-shift select (odd path only) |
| rsp_valid_o | output | 1 | Result word is available |
| rsp_ready_i | input | 1 | Sequencer consumes the result |
| rsp_data_o | output | 32 | Result word |
| mem_req_valid_o | output | 1 | Read request to memory |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 32 | Word-aligned read address |
| mem_rsp_valid_i | input | 1 | Memory returns read data |
| mem_rsp_ready_o | output | 1 | Block accepts read data |
| mem_rsp_data_i | input | 32 | Read data from memory |

## Verification
The bound checker watches the handshake rules on every cycle:
- a read request and its address hold while stalled;
- no more than one read is ever outstanding;
- read addresses stay word aligned;
- the response appears only directly after the last data beat and holds while back-pressured;
- the request port is ready only when the block is idle.

The bench's scenarios cover what depends on values and sequences:
- the splice and the shift arithmetic;
- the count and addresses of the reads on each path;
- masking of the high address bits and the unmasked wrap of the second address;
- the select input having no effect on the aligned path;
- recovery after a reset in the middle of a transfer.

// File: rtl/realign_pkg.sv
package realign_pkg;
  localparam int unsigned RL_ADDR_W     = 32;
  localparam int unsigned RL_DATA_W     = 32;
  localparam int unsigned RL_PHYS_AW    = 27;
  localparam int unsigned RL_BYTE_W     = 8;
  localparam int unsigned RL_SEL_W      = 1;
  localparam int unsigned RL_SHIFT_STEP = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0_REQ,
    ST_RD0_WAIT,
    ST_RD1_REQ,
    ST_RD1_WAIT,
    ST_RSP
  } rl_state_e;
endpackage

// File: rtl/realign_addr_gen.sv
module realign_addr_gen #(
  parameter int unsigned ADDR_W  = realign_pkg::RL_ADDR_W,
  parameter int unsigned DATA_W  = realign_pkg::RL_DATA_W,
  parameter int unsigned PHYS_AW = realign_pkg::RL_PHYS_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              second_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              odd_o
);
  localparam int unsigned WORD_BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] PHYS_MASK = (ADDR_W'(1) << PHYS_AW) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(WORD_BYTES) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] ADDR_MASK = PHYS_MASK & ALIGN_MASK;
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] base_q;
  logic              odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      odd_q  <= 1'b0;
    end else if (load_i) begin
      base_q <= addr_i & ADDR_MASK;
      odd_q  <= addr_i[0];
    end
  end

  // second word address is not re-masked
  assign mem_addr_o = base_q + (second_i ? WORD_STEP : '0);
  assign odd_o      = odd_q;
endmodule

// File: rtl/realign_merge.sv
module realign_merge #(
  parameter int unsigned DATA_W     = realign_pkg::RL_DATA_W,
  parameter int unsigned BYTE_W     = realign_pkg::RL_BYTE_W,
  parameter int unsigned SEL_W      = realign_pkg::RL_SEL_W,
  parameter int unsigned SHIFT_STEP = realign_pkg::RL_SHIFT_STEP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              cap0_i,
  input  logic              cap1_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              odd_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned LOW_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] word0_q;
  logic [BYTE_W-1:0] byte1_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] spliced;
  logic [DATA_W-1:0] shifted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word0_q <= '0;
      byte1_q <= '0;
      sel_q   <= '0;
    end else begin
      if (load_i) sel_q   <= sel_i;
      if (cap0_i) word0_q <= data_i;
      if (cap1_i) byte1_q <= data_i[DATA_W-1 -: BYTE_W];
    end
  end

  assign spliced = {word0_q[LOW_W-1:0], byte1_q};

  generate
    if (SEL_W == 1) begin : g_mux_shift
      assign shifted = sel_q[0] ? (spliced >> SHIFT_STEP) : spliced;
    end else begin : g_var_shift
      assign shifted = spliced >> (int'(sel_q) * SHIFT_STEP);
    end
  endgenerate

  assign data_o = odd_i ? shifted : word0_q;
endmodule

// File: rtl/realign_ctrl.sv
module realign_ctrl
  import realign_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  output logic req_ready_o,
  output logic rsp_valid_o,
  input  logic rsp_ready_i,
  output logic mem_req_valid_o,
  input  logic mem_req_ready_i,
  input  logic mem_rsp_valid_i,
  output logic mem_rsp_ready_o,
  input  logic odd_i,
  output logic load_o,
  output logic cap0_o,
  output logic cap1_o,
  output logic second_o
);
  rl_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d         = state_q;
    req_ready_o     = 1'b0;
    rsp_valid_o     = 1'b0;
    mem_req_valid_o = 1'b0;
    mem_rsp_ready_o = 1'b0;
    load_o          = 1'b0;
    cap0_o          = 1'b0;
    cap1_o          = 1'b0;
    second_o        = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready_o = 1'b1;
        load_o      = req_valid_i;
        if (req_valid_i) state_d = ST_RD0_REQ;
      end
      ST_RD0_REQ: begin
        mem_req_valid_o = 1'b1;
        if (mem_req_ready_i) state_d = ST_RD0_WAIT;
      end
      ST_RD0_WAIT: begin
        mem_rsp_ready_o = 1'b1;
        if (mem_rsp_valid_i) begin
          cap0_o  = 1'b1;
          state_d = odd_i ? ST_RD1_REQ : ST_RSP;
        end
      end
      ST_RD1_REQ: begin
        mem_req_valid_o = 1'b1;
        second_o        = 1'b1;
        if (mem_req_ready_i) state_d = ST_RD1_WAIT;
      end
      ST_RD1_WAIT: begin
        mem_rsp_ready_o = 1'b1;
        second_o        = 1'b1;
        if (mem_rsp_valid_i) begin
          cap1_o  = 1'b1;
          state_d = ST_RSP;
        end
      end
      ST_RSP: begin
        rsp_valid_o = 1'b1;
        if (rsp_ready_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/src_word_realigner.sv
module src_word_realigner #(
  parameter int unsigned ADDR_W     = realign_pkg::RL_ADDR_W,
  parameter int unsigned DATA_W     = realign_pkg::RL_DATA_W,
  parameter int unsigned PHYS_AW    = realign_pkg::RL_PHYS_AW,
  parameter int unsigned BYTE_W     = realign_pkg::RL_BYTE_W,
  parameter int unsigned SEL_W      = realign_pkg::RL_SEL_W,
  parameter int unsigned SHIFT_STEP = realign_pkg::RL_SHIFT_STEP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SEL_W-1:0]  req_shift_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic [DATA_W-1:0] mem_rsp_data_i
);
  logic load, cap0, cap1, second, odd;

  realign_ctrl u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_ready_i     (rsp_ready_i),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_ready_o (mem_rsp_ready_o),
    .odd_i           (odd),
    .load_o          (load),
    .cap0_o          (cap0),
    .cap1_o          (cap1),
    .second_o        (second)
  );

  realign_addr_gen #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PHYS_AW (PHYS_AW)
  ) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .addr_i     (req_addr_i),
    .second_i   (second),
    .mem_addr_o (mem_req_addr_o),
    .odd_o      (odd)
  );

  realign_merge #(
    .DATA_W     (DATA_W),
    .BYTE_W     (BYTE_W),
    .SEL_W      (SEL_W),
    .SHIFT_STEP (SHIFT_STEP)
  ) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .sel_i  (req_shift_i),
    .cap0_i (cap0),
    .cap1_i (cap1),
    .data_i (mem_rsp_data_i),
    .odd_i  (odd),
    .data_o (rsp_data_o)
  );
endmodule

// File: rtl/realign_checker.sv
module realign_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic              mem_rsp_valid_i,
  input logic              mem_rsp_ready_o
);
  logic [1:0] outstanding_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outstanding_q <= '0;
    else outstanding_q <= outstanding_q
                          + 2'(mem_req_valid_o && mem_req_ready_i)
                          - 2'(mem_rsp_valid_i && mem_rsp_ready_o);
  end

  p_ready_when_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!rsp_valid_o && !mem_req_valid_o && !mem_rsp_ready_o));

  p_rsp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));

  p_rsp_after_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $past(mem_rsp_valid_i && mem_rsp_ready_o));

  p_rsp_no_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (outstanding_q == 2'd0));

  p_mem_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  p_single_outstanding_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (outstanding_q == 2'd0));

  p_word_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_addr_o[1:0] == 2'b00));
endmodule

bind src_word_realigner realign_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_src_word_realigner.sv
`timescale 1ns/1ps
module tb_src_word_realigner;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic [0:0]  req_shift_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [31:0] rsp_data_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic        mem_rsp_ready_o;
  logic [31:0] mem_rsp_data_i = '0;

  src_word_realigner dut (.*);

  always #4 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 0;

  // memory responder state
  int          lat_cfg = 0;
  bit          stall_en = 0;
  bit          pend = 0, rq_fire = 0, rs_fire = 0;
  int          cnt = 0;
  logic [31:0] paddr = '0;
  logic [31:0] log_addr [4];
  int          log_ret [4];
  int          n_log = 0, n_ret = 0;
  int          last_ret_edge = -10;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        mem_rsp_valid_i = 1'b0; mem_req_ready_i = 1'b0;
        pend = 0; rq_fire = 0; rs_fire = 0;
        continue;
      end
      if (rs_fire) begin mem_rsp_valid_i = 1'b0; n_ret++; end
      if (rq_fire) begin pend = 1; cnt = lat_cfg; end
      if (pend && !mem_rsp_valid_i) begin
        if (cnt == 0) begin
          mem_rsp_valid_i = 1'b1; mem_rsp_data_i = mem_word(paddr); pend = 0;
        end else cnt--;
      end
      mem_req_ready_i = stall_en ? (cyc % 3 != 0) : 1'b1;
      rq_fire = mem_req_valid_o && mem_req_ready_i;
      if (rq_fire) begin
        paddr = mem_req_addr_o;
        if (n_log < 4) begin log_addr[n_log] = paddr; log_ret[n_log] = n_ret; end
        n_log++;
      end
      rs_fire = mem_rsp_valid_i && mem_rsp_ready_o;
      if (rs_fire) last_ret_edge = cyc + 1;
    end
  end

  task automatic run_txn(logic [31:0] addr, logic sel, int lat, bit stall, int hold);
    logic [31:0] base, w0, w1, exp, held;
    bit busy_ok, hold_ok;
    int n;
    string dtag;
    lat_cfg = lat; stall_en = stall;
    @(negedge clk_i);
    n_log = 0; n_ret = 0;
    req_addr_i = addr; req_shift_i = sel; req_valid_i = 1'b1;
    n = 0;
    while (!req_ready_o && n < 100) begin @(negedge clk_i); n++; end
    @(negedge clk_i);
    req_addr_i = 32'hDEAD_BEE1;  // stays offered while busy
    busy_ok = 1; n = 0;
    while (!rsp_valid_o && n < 200) begin
      if (req_ready_o) busy_ok = 0;
      @(negedge clk_i); n++;
    end
    base = addr & 32'h07FF_FFFC;
    w0 = mem_word(base);
    w1 = mem_word(base + 32'd4);
    if (addr[0]) begin
      exp = {w0[23:0], w1[31:24]};
      if (sel) exp = exp >> 16;
      dtag = sel ? "R4" : "R3";
    end else begin
      exp = w0;
      dtag = sel ? "R10" : "R1";
    end
    chk(rsp_valid_o, "R6", "response arrives", 32'(rsp_valid_o), 32'd1);
    chk(last_ret_edge == cyc, "R6", "response one cycle after last data", 32'(last_ret_edge), 32'(cyc));
    chk(rsp_data_o == exp, dtag, "result word", rsp_data_o, exp);
    chk(n_log == (addr[0] ? 2 : 1), addr[0] ? "R2" : "R1", "read count", 32'(n_log), addr[0] ? 32'd2 : 32'd1);
    chk(log_addr[0] == base, "R5", "first read address", log_addr[0], base);
    if (addr[0]) begin
      chk(log_addr[1] == base + 32'd4, "R2", "second read address", log_addr[1], base + 32'd4);
      chk(log_ret[1] == 1, "R8", "second read after first return", 32'(log_ret[1]), 32'd1);
    end
    held = rsp_data_o; hold_ok = 1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk_i);
      if (!rsp_valid_o || rsp_data_o != held || req_ready_o) hold_ok = 0;
      if (req_ready_o) busy_ok = 0;
    end
    chk(hold_ok, "R6", "response held under back-pressure", 32'(hold_ok), 32'd1);
    chk(busy_ok, "R7", "no request taken while busy", 32'(busy_ok), 32'd1);
    rsp_ready_i = 1'b1; req_valid_i = 1'b0;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    chk(!rsp_valid_o && req_ready_o, "R7", "idle after consume", {rsp_valid_o, req_ready_o}, 32'b01);
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic        sel;
    logic [1:0]  lat;
    logic        stall;
    logic [1:0]  hold;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_1000, 1'b0, 2'd0, 1'b0, 2'd0},
    '{32'h0000_1001, 1'b0, 2'd0, 1'b0, 2'd1},
    '{32'h0000_2003, 1'b1, 2'd1, 1'b0, 2'd2},
    '{32'h0000_0006, 1'b1, 2'd0, 1'b1, 2'd0},
    '{32'hF800_0011, 1'b1, 2'd2, 1'b1, 2'd1},
    '{32'hFFFF_FFFF, 1'b0, 2'd3, 1'b1, 2'd3},
    '{32'h0123_4565, 1'b1, 2'd0, 1'b1, 2'd0},
    '{32'h0400_0004, 1'b1, 2'd3, 1'b0, 2'd2}
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !rsp_valid_o && !mem_req_valid_o, "R9", "outputs during reset",
        {req_ready_o, rsp_valid_o, mem_req_valid_o}, 32'b100);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !rsp_valid_o && !mem_req_valid_o, "R9", "outputs after reset",
        {req_ready_o, rsp_valid_o, mem_req_valid_o}, 32'b100);

    foreach (VECS[i])
      run_txn(VECS[i].addr, VECS[i].sel, int'(VECS[i].lat), VECS[i].stall, int'(VECS[i].hold));

    // reset in the middle of an odd transfer
    lat_cfg = 3; stall_en = 0;
    @(negedge clk_i);
    req_addr_i = 32'h0000_0101; req_shift_i = 1'b0; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(req_ready_o && !rsp_valid_o && !mem_req_valid_o, "R9", "abort by reset",
        {req_ready_o, rsp_valid_o, mem_req_valid_o}, 32'b100);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!rsp_valid_o && !mem_req_valid_o, "R9", "no activity after abort",
        {rsp_valid_o, mem_req_valid_o}, 32'b00);

    run_txn(32'h0000_0205, 1'b0, 1, 1'b1, 1);
    run_txn(32'h0000_0300, 1'b1, 0, 1'b0, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule